// File: doc/BRIEF.md
# Memory Address Decode and Remap Unit

This unit sits between the bus masters and the memory system. Every bus cycle it takes an address (from the CPU, or from the DMA engine when a DMA cycle has been announced) together with a few control settings. From these it produces a preselect strobe for the memory class that owns the address: boot ROM, ROM/Flash, RAM or the I/O pages. It also reports the data width of that memory and the physical address to present to it. Addresses that fall in no region raise an error instead of a strobe.

ROM/Flash can either sit at the bottom of the map, with boot ROM hidden, or be moved up to a second base so that boot ROM becomes visible at the bottom. In the moved placement, the base offset is taken off the address before it reaches the ROM. Two one-shot flags change the next access. A patch flag redirects a ROM hit to a patch memory. A DMA flag makes the next address come from the DMA engine, and it strobes the I/O pages together with the memory, because a DMA transfer moves data between memory and I/O within one bus cycle.

All results are registered. An access presented in one cycle shows its result after the next rising clock edge.

Top module: `mem_decode_remap`

## Requirements
- R1: While reset is asserted and right after it, every strobe and dec_err_o are low, width_o is 00 and phys_addr_o is 0. No patch or DMA flag is pending.
- R2: With rom_remap_i low, addresses 0x000000–0x1FFFFF select ROM/Flash with phys_addr_o equal to the address. Addresses 0x200000–0x3FFFFF raise dec_err_o.
- R3: With rom_remap_i high, addresses 0x000000–0x0FFFFF select boot ROM and addresses 0x100000–0x1FFFFF raise dec_err_o. Addresses 0x200000–0x3FFFFF select ROM/Flash with phys_addr_o equal to the address minus 0x200000.
- R4: Addresses 0x400000–0x4FFFFF select RAM and 0xF00000–0xFFFFFF select the I/O pages, each with phys_addr_o equal to the address. Every other address raises dec_err_o, asserts no strobe and gives phys_addr_o 0.
- R5: width_o uses the codes 00 = 8-bit, 01 = 16-bit and 10 = 32-bit. ROM/Flash and patch accesses report rom_width_i and RAM accesses report ram_width_i. Boot ROM reports the BOOT_WIDTH parameter (default 01). I/O reports 10. An input code of 11 is reported as 10, and an error or idle cycle reports 00.
- R6: The result of a cycle with acc_valid_i high appears after the next rising edge. A cycle with acc_valid_i low yields all strobes low, dec_err_o low, width 00 and address 0.
- R7: A high patch_flag_i arms a patch. The next access that decodes to ROM/Flash asserts sel_patch_o instead of sel_rom_o, with the same address and width. The pending patch clears after that one access, whatever region it decoded to. Idle cycles keep it pending.
- R8: A high dma_flag_i arms a DMA cycle. The next access decodes dma_addr_i instead of cpu_addr_i and asserts sel_io_o together with the boot ROM, ROM/Flash, patch or RAM strobe. A DMA address in the I/O pages or in no region raises dec_err_o with no strobe. The DMA flag clears after one access.
- R9: A flag raised in the same cycle as an access does not affect that access. It applies to the next access.
- R10: At most one of boot, ROM, patch and RAM strobes is high. dec_err_o is never high together with any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | A bus access takes place this cycle |
| cpu_addr_i | input | 24 | CPU address |
| dma_addr_i | input | 24 | DMA engine address |
| patch_flag_i | input | 1 | Redirect the next ROM access to patch memory |
| dma_flag_i | input | 1 | Next access is a DMA cycle |
| rom_remap_i | input | 1 | Place ROM/Flash at 0x200000 and expose boot ROM |
| rom_width_i | input | 2 | ROM/Flash data width code |
| ram_width_i | input | 2 | RAM data width code |
| sel_boot_o | output | 1 | Boot ROM preselect |
| sel_rom_o | output | 1 | ROM/Flash preselect |
| sel_patch_o | output | 1 | Patch memory preselect |
| sel_ram_o | output | 1 | RAM preselect |
| sel_io_o | output | 1 | I/O pages preselect |
| dec_err_o | output | 1 | Address in no region |
| width_o | output | 2 | Data width code of selected memory |
| phys_addr_o | output | 24 | Address presented to selected memory |

## Verification
Each decode result is due one rising edge after the cycle in which its access is presented. A patch or DMA flag counts only from the cycle after the one that raised it. The bench changes every input on the falling edge, then waits for the next falling edge before it compares the whole output set against a value computed from the address map. It keeps its own record of the pending flags, which it advances by the same one-access rule, so flag effects, same-cycle flags and flags held through idle cycles are all predicted without looking inside the design.

// File: rtl/mem_dec_pkg.sv
package mem_dec_pkg;
  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_BOOT,
    RGN_ROM,
    RGN_RAM,
    RGN_IO
  } rgn_e;

  localparam logic [1:0] WCODE_8  = 2'b00;
  localparam logic [1:0] WCODE_16 = 2'b01;
  localparam logic [1:0] WCODE_32 = 2'b10;

  // reserved code 11 folds onto 32-bit
  function automatic logic [1:0] norm_width(input logic [1:0] code);
    return (code == 2'b11) ? WCODE_32 : code;
  endfunction
endpackage

// File: rtl/dec_access_flag.sv
module dec_access_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic use_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (use_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R9: raising the flag always leaves it pending for the next access
  p_arm_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);

  // R7/R8: one access consumes a pending flag
  p_clear_after_use_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && use_i && !set_i) |=> !pend_o);
endmodule

// File: rtl/dec_region.sv
module dec_region
  import mem_dec_pkg::*;
#(
  parameter int unsigned BOOT_NIB = 0,
  parameter int unsigned ROM_NIB  = 2,
  parameter int unsigned RAM_NIB  = 4,
  parameter int unsigned IO_NIB   = 15
) (
  input  logic [3:0] nib_i,
  input  logic       remap_i,
  output rgn_e       rgn_o
);
  localparam logic [3:0] BootN  = 4'(BOOT_NIB);
  localparam logic [3:0] RomLoN = 4'(ROM_NIB);
  localparam logic [3:0] RomHiN = 4'(ROM_NIB + 1);
  localparam logic [3:0] RamN   = 4'(RAM_NIB);
  localparam logic [3:0] IoN    = 4'(IO_NIB);

  always_comb begin
    rgn_o = RGN_NONE;
    if (nib_i == RamN)                                rgn_o = RGN_RAM;
    else if (nib_i == IoN)                            rgn_o = RGN_IO;
    else if (remap_i) begin
      if (nib_i == BootN)                             rgn_o = RGN_BOOT;
      else if (nib_i == RomLoN || nib_i == RomHiN)    rgn_o = RGN_ROM;
    end else begin
      // unmoved ROM occupies the two lowest slots, boot ROM hidden
      if (nib_i == BootN || nib_i == BootN + 4'd1)    rgn_o = RGN_ROM;
    end
  end
endmodule

// File: rtl/dec_phys_addr.sv
module dec_phys_addr
  import mem_dec_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned ROM_NIB = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  rgn_e              rgn_i,
  input  logic              remap_i,
  output logic [ADDR_W-1:0] phys_o
);
  localparam int unsigned NibShift = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] RomOffset = ADDR_W'(ROM_NIB) << NibShift;

  always_comb begin
    phys_o = addr_i;
    if (rgn_i == RGN_ROM && remap_i) phys_o = addr_i - RomOffset;
  end
endmodule

// File: rtl/mem_decode_remap.sv
module mem_decode_remap
  import mem_dec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned BOOT_NIB   = 0,
  parameter int unsigned ROM_NIB    = 2,
  parameter int unsigned RAM_NIB    = 4,
  parameter int unsigned IO_NIB     = 15,
  parameter logic [1:0]  BOOT_WIDTH = 2'b01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic              patch_flag_i,
  input  logic              dma_flag_i,
  input  logic              rom_remap_i,
  input  logic [1:0]        rom_width_i,
  input  logic [1:0]        ram_width_i,
  output logic              sel_boot_o,
  output logic              sel_rom_o,
  output logic              sel_patch_o,
  output logic              sel_ram_o,
  output logic              sel_io_o,
  output logic              dec_err_o,
  output logic [1:0]        width_o,
  output logic [ADDR_W-1:0] phys_addr_o
);
  localparam int unsigned NumFlags = 2;
  localparam int unsigned FlPatch  = 0;
  localparam int unsigned FlDma    = 1;

  logic [NumFlags-1:0] flag_set, flag_pend;
  assign flag_set = {dma_flag_i, patch_flag_i};

  for (genvar g = 0; g < NumFlags; g++) begin : g_flag
    dec_access_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .use_i  (acc_valid_i),
      .pend_o (flag_pend[g])
    );
  end

  logic patch_pend, dma_pend;
  assign patch_pend = flag_pend[FlPatch];
  assign dma_pend   = flag_pend[FlDma];

  logic [ADDR_W-1:0] addr_eff, phys_c;
  rgn_e              rgn;
  assign addr_eff = dma_pend ? dma_addr_i : cpu_addr_i;

  dec_region #(
    .BOOT_NIB (BOOT_NIB),
    .ROM_NIB  (ROM_NIB),
    .RAM_NIB  (RAM_NIB),
    .IO_NIB   (IO_NIB)
  ) u_region (
    .nib_i   (addr_eff[ADDR_W-1 -: 4]),
    .remap_i (rom_remap_i),
    .rgn_o   (rgn)
  );

  dec_phys_addr #(
    .ADDR_W  (ADDR_W),
    .ROM_NIB (ROM_NIB)
  ) u_phys (
    .addr_i  (addr_eff),
    .rgn_i   (rgn),
    .remap_i (rom_remap_i),
    .phys_o  (phys_c)
  );

  logic              boot_c, rom_c, patch_c, ram_c, io_c, err_c, mem_c;
  logic [1:0]        width_c;
  logic [ADDR_W-1:0] addr_c;

  always_comb begin
    boot_c  = 1'b0;
    rom_c   = 1'b0;
    patch_c = 1'b0;
    ram_c   = 1'b0;
    io_c    = 1'b0;
    err_c   = 1'b0;
    width_c = WCODE_8;
    if (acc_valid_i) begin
      unique case (rgn)
        RGN_BOOT: begin
          boot_c  = 1'b1;
          width_c = norm_width(BOOT_WIDTH);
        end
        RGN_ROM: begin
          patch_c = patch_pend;
          rom_c   = !patch_pend;
          width_c = norm_width(rom_width_i);
        end
        RGN_RAM: begin
          ram_c   = 1'b1;
          width_c = norm_width(ram_width_i);
        end
        RGN_IO: begin
          // DMA must name the memory side of its transfer
          err_c   = dma_pend;
          io_c    = !dma_pend;
          width_c = dma_pend ? WCODE_8 : WCODE_32;
        end
        default: err_c = 1'b1;
      endcase
    end
    mem_c = boot_c | rom_c | patch_c | ram_c;
    if (dma_pend && mem_c) io_c = 1'b1;
    addr_c = (acc_valid_i && !err_c) ? phys_c : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_boot_o  <= 1'b0;
      sel_rom_o   <= 1'b0;
      sel_patch_o <= 1'b0;
      sel_ram_o   <= 1'b0;
      sel_io_o    <= 1'b0;
      dec_err_o   <= 1'b0;
      width_o     <= WCODE_8;
      phys_addr_o <= '0;
    end else begin
      sel_boot_o  <= boot_c;
      sel_rom_o   <= rom_c;
      sel_patch_o <= patch_c;
      sel_ram_o   <= ram_c;
      sel_io_o    <= io_c;
      dec_err_o   <= err_c;
      width_o     <= width_c;
      phys_addr_o <= addr_c;
    end
  end

  logic any_mem_o;
  assign any_mem_o = sel_boot_o | sel_rom_o | sel_patch_o | sel_ram_o;

  p_onehot_mem_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_boot_o, sel_rom_o, sel_patch_o, sel_ram_o}));

  p_err_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_err_o |-> !(any_mem_o || sel_io_o));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !(any_mem_o || sel_io_o || dec_err_o) && phys_addr_o == '0);

  // I/O together with memory only on a pending DMA access
  p_dma_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !dma_pend) |=> !(sel_io_o && any_mem_o));

  p_patch_only_armed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !patch_pend |=> !sel_patch_o);

  p_io_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_io_o && !any_mem_o) |-> width_o == WCODE_32);
endmodule

// File: tb/mem_decode_remap_tb_top.sv
`timescale 1ns/1ps
module mem_decode_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [23:0] cpu_a = '0, dma_a = '0;
  logic        pflag = 1'b0, dflag = 1'b0, remap = 1'b0;
  logic [1:0]  romw = 2'b00, ramw = 2'b00;
  logic        s_boot, s_rom, s_patch, s_ram, s_io, err;
  logic [1:0]  w;
  logic [23:0] phys;

  int checks = 0, fails = 0;
  bit patch_p = 1'b0, dma_p = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_decode_remap dut_i (
    .clk_i (clk), .rst_ni (rst_n), .acc_valid_i (valid),
    .cpu_addr_i (cpu_a), .dma_addr_i (dma_a),
    .patch_flag_i (pflag), .dma_flag_i (dflag), .rom_remap_i (remap),
    .rom_width_i (romw), .ram_width_i (ramw),
    .sel_boot_o (s_boot), .sel_rom_o (s_rom), .sel_patch_o (s_patch),
    .sel_ram_o (s_ram), .sel_io_o (s_io), .dec_err_o (err),
    .width_o (w), .phys_addr_o (phys)
  );

  function automatic logic [1:0] nw(input logic [1:0] c);
    return (c == 2'b11) ? 2'b10 : c;
  endfunction

  // packed {boot,rom,patch,ram,io,err,width[1:0],phys[23:0]}
  function automatic logic [31:0] model(input bit v, input logic [23:0] a,
      input logic [23:0] da, input bit rm, input logic [1:0] rw,
      input logic [1:0] mw, input bit pp, input bit dp);
    logic [23:0] ad;
    logic [3:0]  n;
    bit bo, ro, pa, ra, io, er;
    logic [1:0]  wd;
    logic [23:0] ph;
    bo = 0; ro = 0; pa = 0; ra = 0; io = 0; er = 0; wd = 2'b00; ph = '0;
    if (!v) return '0;
    ad = dp ? da : a;
    n  = ad[23:20];
    if (n == 4'h4) begin ra = 1; wd = nw(mw); ph = ad; end
    else if (n == 4'hF) begin
      if (dp) er = 1; else begin io = 1; wd = 2'b10; ph = ad; end
    end
    else if (rm && n == 4'h0) begin bo = 1; wd = 2'b01; ph = ad; end
    else if (rm && (n == 4'h2 || n == 4'h3)) begin
      ro = 1; wd = nw(rw); ph = ad - 24'h200000;
    end
    else if (!rm && n <= 4'h1) begin ro = 1; wd = nw(rw); ph = ad; end
    else er = 1;
    if (ro && pp) begin ro = 0; pa = 1; end
    if (dp && (bo || ro || pa || ra)) io = 1;
    return {bo, ro, pa, ra, io, er, wd, ph};
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    logic [31:0] act;
    act = {s_boot, s_rom, s_patch, s_ram, s_io, err, w, phys};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle, checks at next falling edge
  task automatic cyc(input string req, input bit v, input logic [23:0] a,
      input logic [23:0] da, input bit p, input bit d);
    logic [31:0] exp;
    valid = v; cpu_a = a; dma_a = da; pflag = p; dflag = d;
    exp = model(v, a, da, remap, romw, ramw, patch_p, dma_p);
    patch_p = p ? 1'b1 : (v ? 1'b0 : patch_p);
    dma_p   = d ? 1'b1 : (v ? 1'b0 : dma_p);
    @(negedge clk);
    check(req, exp);
    pflag = 1'b0; dflag = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] offs [3];
    offs[0] = 24'h000000; offs[1] = 24'h0ABCDE; offs[2] = 24'h0FFFFF;
    valid = 1'b1; cpu_a = 24'h400010; pflag = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", '0);
    rst_n = 1'b1;
    valid = 1'b0; pflag = 1'b0;
    @(negedge clk);
    check("R1 after reset", '0);
    // flags must be clear: a ROM access shows no patch and no DMA
    cyc("R1 flags clear", 1, 24'h010000, 24'h400000, 0, 0);

    // sweep of the whole map under both placements, R2 R3 R4 R5
    for (int rm = 0; rm < 2; rm++) begin
      remap = rm[0];
      for (int n = 0; n < 16; n++) begin
        for (int k = 0; k < 3; k++) begin
          romw = 2'(n + k);
          ramw = 2'(n + k + 1);
          cyc(rm ? "R3 R4 R5 map moved" : "R2 R4 R5 map low", 1,
              {4'(n), 20'h0} | offs[k], 24'h0, 0, 0);
        end
      end
    end

    romw = 2'b11; ramw = 2'b00; remap = 1'b0;
    cyc("R6 idle", 0, 24'h400000, 24'h0, 0, 0);
    cyc("R5 code 11 as 32", 1, 24'h123456, 24'h0, 0, 0);

    // patch: arm, hold through idle, then ROM access redirected
    romw = 2'b01; remap = 1'b1;
    cyc("R7 arm", 0, 24'h0, 24'h0, 1, 0);
    cyc("R7 idle keeps", 0, 24'h0, 24'h0, 0, 0);
    cyc("R7 patch hit", 1, 24'h2ABCDE, 24'h0, 0, 0);
    cyc("R7 cleared", 1, 24'h2ABCDE, 24'h0, 0, 0);
    cyc("R7 arm", 0, 24'h0, 24'h0, 1, 0);
    cyc("R7 consumed by RAM", 1, 24'h400100, 24'h0, 0, 0);
    cyc("R7 no patch after", 1, 24'h300004, 24'h0, 0, 0);
    remap = 1'b0;
    cyc("R7 arm low map", 0, 24'h0, 24'h0, 1, 0);
    cyc("R7 patch low map", 1, 24'h1FFFFC, 24'h0, 0, 0);

    // same-cycle flag applies to the following access
    cyc("R9 same cycle patch", 1, 24'h000040, 24'h0, 1, 0);
    cyc("R9 next gets patch", 1, 24'h000040, 24'h0, 0, 0);
    cyc("R9 same cycle dma", 1, 24'hF00008, 24'h400020, 0, 1);
    cyc("R9 next gets dma", 1, 24'hF00008, 24'h400020, 0, 0);

    // DMA cycles
    remap = 1'b1; ramw = 2'b10;
    cyc("R8 arm", 0, 24'h0, 24'h0, 0, 1);
    cyc("R8 ram+io", 1, 24'hF00000, 24'h4FFFF0, 0, 0);
    cyc("R8 cleared", 1, 24'hF00000, 24'h4FFFF0, 0, 0);
    cyc("R8 arm", 0, 24'h0, 24'h0, 0, 1);
    cyc("R8 boot+io", 1, 24'h400000, 24'h0F0000, 0, 0);
    cyc("R8 arm", 0, 24'h0, 24'h0, 0, 1);
    cyc("R8 dma into io err", 1, 24'h400000, 24'hF12345, 0, 0);
    cyc("R8 arm", 0, 24'h0, 24'h0, 0, 1);
    cyc("R8 dma unmapped err", 1, 24'h400000, 24'h812345, 0, 0);
    cyc("R7 R8 arm both", 0, 24'h0, 24'h0, 1, 1);
    cyc("R7 R8 patch+io", 1, 24'h0, 24'h380000, 0, 0);
    cyc("R6 idle end", 0, 24'h0, 24'h0, 0, 0);

    finish_run();
  end
endmodule